// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the processor's current status word and sequences exceptions around it. The status word carries the arithmetic flags, two interrupt masks and the current mode. When an exception request is taken, the block does four things. It saves the old status word and the faulting program counter into the target mode's private copies. It switches mode and sets the masks. In the following cycle it raises a program-counter redirect to that exception's vector.

A return command reverses the entry. It reloads the status word from the current mode's saved copy and redirects to the saved link address, adjusted by the kind of exception. Software writes to the status word are filtered by privilege. Any mode may change the flags, but only privileged modes may change the masks or the mode.

The core that uses the block supplies the program counter of the affected instruction on `pc_i`. It follows `redirect_o`/`redirect_pc_o` one cycle after the request. It reads the current mode and masks from the outputs.

Top module: `exc_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset the mode is supervisor, both interrupt masks are set, the flags are zero and no redirect is signalled.
- R2: Among simultaneous requests exactly one is taken. The order is reset request, data abort, FIQ, IRQ, prefetch abort, undefined, then software call.
- R3: An IRQ request is ignored while the IRQ mask (status bit 7) is set, and an FIQ request is ignored while the FIQ mask (status bit 6) is set.
- R4: A taken exception other than reset stores the pre-entry status word and `pc_i` in the target mode's saved-status and link copies, then switches mode. The mode codes are user 0, FIQ 1, IRQ 2, supervisor 3, abort 4, undefined 5 and system 6. Both aborts enter abort, undefined enters undefined, a software call enters supervisor, and IRQ and FIQ enter their own modes.
- R5: FIQ entry sets both masks. Every other exception entry sets the IRQ mask and leaves the FIQ mask unchanged.
- R6: One cycle after any taken exception, `redirect_o` is high for one cycle with `redirect_pc_o` = VEC_BASE + offset. The offsets are: reset 0x00, undefined 0x04, software call 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C.
- R7: A reset request returns the status word to its reset value and redirects to offset 0x00. It leaves the saved copies untouched.
- R8: A return in FIQ, IRQ, supervisor, abort or undefined mode loads the status word from that mode's saved copy and redirects one cycle later. The target is the link value plus 4 for undefined and supervisor, and the link value plus 0 for the other three modes.
- R9: A return in user or system mode changes nothing and raises no redirect.
- R10: A flag write replaces status bits 31:28 with the written bits in every mode.
- R11: A control write replaces the IRQ mask (bit 7), the FIQ mask (bit 6) and the mode (bits 2:0) in every mode except user, where it is ignored. A control write carrying mode code 7 is ignored.
- R12: In one cycle a taken exception overrides a return, and a return overrides status writes.
- R13: `status_o` has all bits other than 31:28, 7, 6 and 2:0 at zero, and `priv_o` is high in every mode except user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req_i | input | 1 | Reset exception request |
| dabt_req_i | input | 1 | Data abort request |
| fiq_req_i | input | 1 | Fast interrupt request |
| irq_req_i | input | 1 | Interrupt request |
| pabt_req_i | input | 1 | Prefetch abort request |
| und_req_i | input | 1 | Unsupported instruction request |
| swc_req_i | input | 1 | Software call request |
| pc_i | input | 32 | Program counter recorded as link on entry |
| ret_i | input | 1 | Return-from-exception command |
| sr_wr_flags_i | input | 1 | Write flag field from sr_wdata_i |
| sr_wr_ctrl_i | input | 1 | Write masks and mode from sr_wdata_i |
| sr_wdata_i | input | 32 | Status write data |
| mode_o | output | 3 | Current mode code |
| priv_o | output | 1 | Current mode is privileged |
| irq_mask_o | output | 1 | IRQ mask |
| fiq_mask_o | output | 1 | FIQ mask |
| status_o | output | 32 | Packed status word |
| redirect_o | output | 1 | PC redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |

## Verification
Directed sequences drive every request together, FIQ and IRQ together, and IRQ under its mask. These show whether the priority order and the mask gating are right, apart from the entry effects. Returns are tried from abort, FIQ, supervisor, user and system modes. This separates per-mode link adjustment from the no-op case. Control writes are sent from user, system and supervisor mode, and with the forbidden mode code, which shows whether the privilege filter works. Long runs of random requests, returns and writes from a fixed seed then mix all of these. The random runs exercise nested entries that overwrite saved copies and same-cycle collisions between exceptions, returns and writes.

// File: rtl/excc_pkg.sv
// Shared types and helper functions for the exception controller.
// Assumes a 32-bit program counter and status word layout:
// [31:28] flags, [7] IRQ mask, [6] FIQ mask, [2:0] mode code.
package excc_pkg;

    typedef enum logic [2:0] {
        M_USR = 3'd0, M_FIQ = 3'd1, M_IRQ = 3'd2, M_SVC = 3'd3,
        M_ABT = 3'd4, M_UND = 3'd5, M_SYS = 3'd6
    } mode_e;

    typedef enum logic [2:0] {
        EX_NONE, EX_RST, EX_DABT, EX_FIQ, EX_IRQ, EX_PABT, EX_UND, EX_SWC
    } exc_e;

    typedef struct packed {
        logic [3:0] flags;
        logic       imask;
        logic       fmask;
        mode_e      mode;
    } stat_t;

    localparam int NUM_BANKS = 5;
    localparam int BANK_IW   = $clog2(NUM_BANKS);

    function automatic logic [31:0] pack_stat(stat_t s);
        return {s.flags, 20'd0, s.imask, s.fmask, 3'd0, 3'(s.mode)};
    endfunction

    function automatic stat_t unpack_stat(logic [31:0] w);
        stat_t s;
        s.flags = w[31:28];
        s.imask = w[7];
        s.fmask = w[6];
        s.mode  = mode_e'(w[2:0]);
        return s;
    endfunction

    function automatic logic has_bank(mode_e m);
        return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND);
    endfunction

    function automatic logic [BANK_IW-1:0] bank_idx(mode_e m);
        return BANK_IW'(3'(m) - 3'd1);
    endfunction

    function automatic mode_e exc_mode(exc_e k);
        case (k)
            EX_DABT, EX_PABT: return M_ABT;
            EX_FIQ:           return M_FIQ;
            EX_IRQ:           return M_IRQ;
            EX_UND:           return M_UND;
            default:          return M_SVC;
        endcase
    endfunction

    function automatic logic [31:0] vec_off(exc_e k);
        case (k)
            EX_UND:  return 32'h04;
            EX_SWC:  return 32'h08;
            EX_PABT: return 32'h0C;
            EX_DABT: return 32'h10;
            EX_IRQ:  return 32'h18;
            EX_FIQ:  return 32'h1C;
            default: return 32'h00;
        endcase
    endfunction

    function automatic logic [31:0] ret_adj(mode_e m);
        return (m == M_UND || m == M_SVC) ? 32'd4 : 32'd0;
    endfunction

endpackage

// File: rtl/excc_arbiter.sv
// Fixed-priority selector for exception requests.
// Assumes the mask inputs come straight from the current status word.
module excc_arbiter
    import excc_pkg::*;
(
    input  logic rst_req,
    input  logic dabt_req,
    input  logic fiq_req,
    input  logic irq_req,
    input  logic pabt_req,
    input  logic und_req,
    input  logic swc_req,
    input  logic imask,
    input  logic fmask,
    output exc_e kind
);

    // Pick the highest-priority request that is not masked.
    always_comb begin
        if (rst_req)                 kind = EX_RST;
        else if (dabt_req)           kind = EX_DABT;
        else if (fiq_req && !fmask)  kind = EX_FIQ;
        else if (irq_req && !imask)  kind = EX_IRQ;
        else if (pabt_req)           kind = EX_PABT;
        else if (und_req)            kind = EX_UND;
        else if (swc_req)            kind = EX_SWC;
        else                         kind = EX_NONE;
    end

endmodule

// File: rtl/excc_bank.sv
// Per-mode saved-status and link storage, one slot per mode that owns a copy.
// Assumes one write per cycle; reads are combinational.
module excc_bank #(
    parameter int NB = 5,
    parameter int DW = 32,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wstat,
    input  logic [DW-1:0] wlink,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rstat,
    output logic [DW-1:0] rlink
);

    logic [DW-1:0] stat_arr [NB];
    logic [DW-1:0] link_arr [NB];

    for (genvar b = 0; b < NB; b++) begin : g_slot
        logic [DW-1:0] stat_q;
        logic [DW-1:0] link_q;

        // Capture status and link when this slot is the entry target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q <= '0;
                link_q <= '0;
            end else if (we && (widx == IW'(b))) begin
                stat_q <= wstat;
                link_q <= wlink;
            end
        end

        assign stat_arr[b] = stat_q;
        assign link_arr[b] = link_q;
    end

    // Read the slot of the current mode; out-of-range reads give zero.
    always_comb begin
        rstat = '0;
        rlink = '0;
        if (ridx < IW'(NB)) begin
            rstat = stat_arr[ridx];
            rlink = link_arr[ridx];
        end
    end

endmodule

// File: rtl/exc_seq_ctrl.sv
// Exception entry/return controller: owns the status word, performs entry
// (save, mode switch, masking, vectoring) and return (restore, redirect),
// and filters software status writes by privilege.
// Assumes requests are level signals sampled each clock edge.
module exc_seq_ctrl
    import excc_pkg::*;
#(
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rst_req_i,
    input  logic        dabt_req_i,
    input  logic        fiq_req_i,
    input  logic        irq_req_i,
    input  logic        pabt_req_i,
    input  logic        und_req_i,
    input  logic        swc_req_i,
    input  logic [31:0] pc_i,
    input  logic        ret_i,
    input  logic        sr_wr_flags_i,
    input  logic        sr_wr_ctrl_i,
    input  logic [31:0] sr_wdata_i,
    output logic [2:0]  mode_o,
    output logic        priv_o,
    output logic        irq_mask_o,
    output logic        fiq_mask_o,
    output logic [31:0] status_o,
    output logic        redirect_o,
    output logic [31:0] redirect_pc_o
);

    logic [3:0]  flags_q;
    logic        imask_q;
    logic        fmask_q;
    mode_e       mode_q;
    logic        redirect_q;
    logic [31:0] redirect_pc_q;

    exc_e                kind;
    stat_t               cur_stat;
    stat_t               rest_stat;
    logic                bank_we;
    logic [BANK_IW-1:0]  bank_widx;
    logic [31:0]         bank_rstat;
    logic [31:0]         bank_rlink;
    logic                ret_ok;
    logic                ctrl_ok;

    excc_arbiter u_arb (
        .rst_req  (rst_req_i),
        .dabt_req (dabt_req_i),
        .fiq_req  (fiq_req_i),
        .irq_req  (irq_req_i),
        .pabt_req (pabt_req_i),
        .und_req  (und_req_i),
        .swc_req  (swc_req_i),
        .imask    (imask_q),
        .fmask    (fmask_q),
        .kind     (kind)
    );

    // Assemble the current status and the decode of this cycle's actions.
    always_comb begin
        cur_stat.flags = flags_q;
        cur_stat.imask = imask_q;
        cur_stat.fmask = fmask_q;
        cur_stat.mode  = mode_q;
        bank_we   = (kind != EX_NONE) && (kind != EX_RST);
        bank_widx = bank_idx(exc_mode(kind));
        ret_ok    = ret_i && (kind == EX_NONE) && has_bank(mode_q);
        ctrl_ok   = sr_wr_ctrl_i && (mode_q != M_USR) && (sr_wdata_i[2:0] != 3'd7);
        rest_stat = unpack_stat(bank_rstat);
    end

    excc_bank #(.NB(NUM_BANKS), .DW(32)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (bank_widx),
        .wstat (pack_stat(cur_stat)),
        .wlink (pc_i),
        .ridx  (bank_idx(mode_q)),
        .rstat (bank_rstat),
        .rlink (bank_rlink)
    );

    // Status word and redirect sequencing: exception, then return, then writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q       <= '0;
            imask_q       <= 1'b1;
            fmask_q       <= 1'b1;
            mode_q        <= M_SVC;
            redirect_q    <= 1'b0;
            redirect_pc_q <= '0;
        end else begin
            redirect_q <= 1'b0;
            if (kind == EX_RST) begin
                flags_q       <= '0;
                imask_q       <= 1'b1;
                fmask_q       <= 1'b1;
                mode_q        <= M_SVC;
                redirect_q    <= 1'b1;
                redirect_pc_q <= VEC_BASE;
            end else if (kind != EX_NONE) begin
                mode_q        <= exc_mode(kind);
                imask_q       <= 1'b1;
                if (kind == EX_FIQ) fmask_q <= 1'b1;
                redirect_q    <= 1'b1;
                redirect_pc_q <= VEC_BASE + vec_off(kind);
            end else if (ret_ok) begin
                flags_q       <= rest_stat.flags;
                imask_q       <= rest_stat.imask;
                fmask_q       <= rest_stat.fmask;
                mode_q        <= rest_stat.mode;
                redirect_q    <= 1'b1;
                redirect_pc_q <= bank_rlink + ret_adj(mode_q);
            end else begin
                if (sr_wr_flags_i) flags_q <= sr_wdata_i[31:28];
                if (ctrl_ok) begin
                    imask_q <= sr_wdata_i[7];
                    fmask_q <= sr_wdata_i[6];
                    mode_q  <= mode_e'(sr_wdata_i[2:0]);
                end
            end
        end
    end

    assign mode_o        = 3'(mode_q);
    assign priv_o        = (mode_q != M_USR);
    assign irq_mask_o    = imask_q;
    assign fiq_mask_o    = fmask_q;
    assign status_o      = pack_stat(cur_stat);
    assign redirect_o    = redirect_q;
    assign redirect_pc_o = redirect_pc_q;

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imask_q |-> (kind != EX_IRQ));

    // R5
    fiq_entry_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EX_FIQ) |=> (imask_o_both() && mode_q == M_FIQ));

    // R6
    entry_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != EX_NONE) |=> redirect_o);

    // R8
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> (status_o == $past(bank_rstat)));

    // R9
    no_ret_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && kind == EX_NONE && !has_bank(mode_q)) |=> !redirect_o);

    // R11
    user_ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_USR && kind == EX_NONE) |=> (mode_q == M_USR));

    function automatic logic imask_o_both();
        return irq_mask_o && fiq_mask_o;
    endfunction

endmodule

// File: tb/exc_seq_ctrl_bench.sv
module exc_seq_ctrl_bench;

    localparam logic [31:0] VB = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req_i = 0, dabt_req_i = 0, fiq_req_i = 0, irq_req_i = 0;
    logic        pabt_req_i = 0, und_req_i = 0, swc_req_i = 0;
    logic [31:0] pc_i = '0;
    logic        ret_i = 0, sr_wr_flags_i = 0, sr_wr_ctrl_i = 0;
    logic [31:0] sr_wdata_i = '0;
    logic [2:0]  mode_o;
    logic        priv_o, irq_mask_o, fiq_mask_o, redirect_o;
    logic [31:0] status_o, redirect_pc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [3:0]  m_flags;
    logic        m_im, m_fm;
    int          m_mode;
    logic [31:0] m_sp [7];
    logic [31:0] m_lr [7];
    logic        e_redir;
    logic [31:0] e_pc;

    always #4 clk = ~clk;

    exc_seq_ctrl #(.VEC_BASE(VB)) u_exc_seq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rst_req_i(rst_req_i), .dabt_req_i(dabt_req_i), .fiq_req_i(fiq_req_i),
        .irq_req_i(irq_req_i), .pabt_req_i(pabt_req_i), .und_req_i(und_req_i),
        .swc_req_i(swc_req_i), .pc_i(pc_i), .ret_i(ret_i),
        .sr_wr_flags_i(sr_wr_flags_i), .sr_wr_ctrl_i(sr_wr_ctrl_i),
        .sr_wdata_i(sr_wdata_i), .mode_o(mode_o), .priv_o(priv_o),
        .irq_mask_o(irq_mask_o), .fiq_mask_o(fiq_mask_o), .status_o(status_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    function automatic logic [31:0] mk(logic [3:0] f, logic i, logic fq, int m);
        return {f, 20'd0, i, fq, 3'd0, 3'(m)};
    endfunction

    function automatic logic [31:0] mpack();
        return mk(m_flags, m_im, m_fm, m_mode);
    endfunction

    task automatic model_reset();
        m_flags = '0; m_im = 1; m_fm = 1; m_mode = 3; e_redir = 0; e_pc = '0;
        for (int i = 0; i < 7; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
    endtask

    task automatic compare(input string tg);
        logic ok;
        ok = (status_o == mpack()) && (mode_o == 3'(m_mode)) &&
             (priv_o == (m_mode != 0)) && (irq_mask_o == m_im) &&
             (fiq_mask_o == m_fm) && (redirect_o == e_redir) &&
             (!e_redir || redirect_pc_o == e_pc);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: status=%h redir=%0d pc=%h expected status=%h redir=%0d pc=%h",
                     tg, status_o, redirect_o, redirect_pc_o, mpack(), e_redir, e_pc);
        end
    endtask

    // rq = {rst, dabt, fiq, irq, pabt, und, swc}
    task automatic step(input logic [6:0] rq, input logic [31:0] pc, input logic rt,
                        input logic wf, input logic wc, input logic [31:0] wd,
                        input string tg_in);
        int k, tm, om;
        string tg;
        @(negedge clk);
        {rst_req_i, dabt_req_i, fiq_req_i, irq_req_i, pabt_req_i, und_req_i, swc_req_i} = rq;
        pc_i = pc; ret_i = rt; sr_wr_flags_i = wf; sr_wr_ctrl_i = wc; sr_wdata_i = wd;
        if (rq[6])                 k = 1;
        else if (rq[5])            k = 2;
        else if (rq[4] && !m_fm)   k = 3;
        else if (rq[3] && !m_im)   k = 4;
        else if (rq[2])            k = 5;
        else if (rq[1])            k = 6;
        else if (rq[0])            k = 7;
        else                       k = 0;
        e_redir = 0;
        if (k == 1) begin
            m_flags = 0; m_im = 1; m_fm = 1; m_mode = 3;
            e_redir = 1; e_pc = VB; tg = "R7";
        end else if (k != 0) begin
            tm = (k == 2 || k == 5) ? 4 : (k == 3) ? 1 : (k == 4) ? 2 : (k == 6) ? 5 : 3;
            m_sp[tm] = mpack(); m_lr[tm] = pc;
            m_mode = tm; m_im = 1; if (k == 3) m_fm = 1;
            e_redir = 1;
            e_pc = VB + ((k == 2) ? 32'h10 : (k == 3) ? 32'h1C : (k == 4) ? 32'h18 :
                         (k == 5) ? 32'h0C : (k == 6) ? 32'h04 : 32'h08);
            tg = "R4";
        end else if (rt && m_mode >= 1 && m_mode <= 5) begin
            om = m_mode;
            m_flags = m_sp[om][31:28]; m_im = m_sp[om][7]; m_fm = m_sp[om][6];
            m_mode = int'(m_sp[om][2:0]);
            e_redir = 1; e_pc = m_lr[om] + ((om == 5 || om == 3) ? 32'd4 : 32'd0);
            tg = "R8";
        end else begin
            tg = rt ? "R9" : (wc ? "R11" : "R10");
            if (wf) m_flags = wd[31:28];
            if (wc && m_mode != 0 && wd[2:0] != 3'd7) begin
                m_im = wd[7]; m_fm = wd[6]; m_mode = int'(wd[2:0]);
            end
        end
        @(posedge clk);
        #1;
        compare((tg_in != "") ? tg_in : tg);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        compare("R1");
        compare("R13");

        // flags + control write from supervisor into user
        step(7'b0, 0, 0, 1, 1, mk(4'hA, 0, 0, 0), "R10");
        // user may not change control; flags still change
        step(7'b0, 0, 0, 1, 1, mk(4'h5, 1, 1, 3), "R11");
        // return in user: no effect
        step(7'b0, 0, 1, 0, 0, 0, "R9");
        // all but reset together: data abort wins
        step(7'b0111111, 32'h200, 0, 0, 0, 0, "R2");
        // IRQ while masked (abort mode set I): ignored
        step(7'b0001000, 32'h300, 0, 0, 0, 0, "R3");
        // return from abort: back to user, link + 0
        step(7'b0, 0, 1, 0, 0, 0, "R8");
        // FIQ and IRQ together from user: FIQ wins, both masks set
        step(7'b0011000, 32'h400, 0, 0, 0, 0, "R5");
        // return from FIQ
        step(7'b0, 0, 1, 0, 0, 0, "R8");
        // IRQ entry keeps F clear
        step(7'b0001000, 32'h480, 0, 0, 0, 0, "R5");
        step(7'b0, 0, 1, 0, 0, 0, "R8");
        // software call: vector 0x08, return adds 4
        step(7'b0000001, 32'h500, 0, 0, 0, 0, "R6");
        // control write with forbidden mode code ignored
        step(7'b0, 0, 0, 0, 1, mk(4'h0, 0, 0, 7), "R11");
        step(7'b0, 0, 1, 0, 0, 0, "R8");
        // undefined then return (+4)
        step(7'b0000010, 32'h600, 0, 0, 0, 0, "R6");
        // exception beats return and write in the same cycle
        step(7'b0000100, 32'h640, 1, 1, 1, mk(4'hF, 0, 0, 6), "R12");
        step(7'b0, 0, 1, 1, 0, mk(4'h3, 0, 0, 0), "R12");
        // reset request from undefined; saved copies kept
        step(7'b1000000, 32'h700, 0, 0, 0, 0, "R7");
        // supervisor into system; system may write control; return ignored
        step(7'b0, 0, 0, 0, 1, mk(4'h0, 0, 0, 6), "R11");
        step(7'b0, 0, 0, 0, 1, mk(4'h0, 1, 0, 6), "R11");
        step(7'b0, 0, 1, 0, 0, 0, "R9");
        step(7'b0, 0, 0, 0, 1, mk(4'h0, 0, 0, 6), "R13");

        for (int n = 0; n < 4000; n++) begin
            logic [6:0]  rq;
            logic [31:0] wd;
            rq[6] = ($urandom % 200) == 0;
            for (int b = 0; b < 6; b++) rq[b] = ($urandom % 14) == 0;
            wd = $urandom;
            if (wd[2:0] == 3'd7 && ($urandom % 4) != 0) wd[2:0] = 3'($urandom % 7);
            step(rq, $urandom & 32'hFFFF_FFFC, ($urandom % 5) == 0,
                 ($urandom % 4) == 0, ($urandom % 5) == 0, wd, "");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule